// File: doc/BRIEF.md
# Merged-layer 2x2 NTT memory scheduler

This block sequences the coefficient memory of an in-place number-theoretic transform engine built from a 2x2 array of butterflies. Two transform layers are merged into each round. In every read cycle it issues four coefficient addresses and the three twiddle-table indices for the group being read. It delays those addresses through four write-back lanes of different depth. The lane depths model the pipeline from the read to the staggered serial-in parallel-out result buffers. It also inserts a fixed quiet gap between rounds, so that a round never reads a word that the previous round has not yet written back.

The transform length is given as its base-2 logarithm `log_n`. When `log_n` is odd, the final forward round covers a single layer, and the first butterfly row is told to pass its data through. The inverse transform runs the rounds in reverse order and reads the forward twiddle table from the top down. The butterfly arithmetic is outside the block and appears here only as a fixed latency.

Top module: `ntt_merge_sched`

## Requirements
- R1: While reset is applied, and after it is released with no start, `rd_en`, every bit of `wr_en`, `busy` and `done` are low.
- R2: A start is accepted only while idle and only with `log_n` between 2 and LOG_N_MAX inclusive. The first read cycle is the cycle right after the accepting clock edge. A start pulse while busy, or one with `log_n` out of range, changes nothing.
- R3: A run of length n = 2^L has ceil(L/2) rounds, and each round has n/4 consecutive read cycles. In a two-layer round of forward stage s = 2r, with m = 2^s and t = n/(4m), groups i = 0..m-1 are read in ascending order. Within a group, j runs upward from 4it to 4it+t-1, and lanes 0..3 of `rd_addr` (lane g in bits g*AW upward) carry j, j+t, j+2t, j+3t.
- R4: In a two-layer forward round, twiddle slots 0, 1 and 2 of `tw_idx` carry m+i, 2(m+i) and 2(m+i)+1.
- R5: When L is odd, the last forward round is single-layer and `bypass_row1` is high on its read cycles and at no other time. For p = 0..n/4-1 its lanes read 4p, 4p+2, 4p+1, 4p+3, and its twiddle slots carry n/4+p, n/2+2p and n/2+2p+1.
- R6: With `inverse` high at start, the rounds come in reverse order with unchanged order inside each round. Every twiddle index x is replaced by n-1-x.
- R7: Write lane g goes high, with the address read on lane g, exactly 14+g cycles after that read. The delay is 2 cycles of RAM read, 8 of butterfly and 4 of buffering, plus a one-cycle stagger per lane.
- R8: The first read of each round after the first comes exactly 7 cycles after the last write of the previous round, which leaves 6 cycles with no read and no write.
- R9: `done` is a one-cycle pulse in the cycle after the last write of the last round. `busy` is high from the first read cycle through that last write and low while `done` is high.
- R10: Reset applied during a run immediately drops `busy`, `rd_en` and all write enables. After release the block is idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform (sampled while idle) |
| inverse | input | 1 | 1 selects the inverse transform, sampled with start |
| log_n | input | LW | Base-2 log of the length, sampled with start |
| rd_en | output | 1 | Read addresses valid this cycle |
| rd_addr | output | 4*AW | Four coefficient read addresses, lane 0 lowest |
| tw_idx | output | 3*AW | Twiddle indices: row-one, row-two upper, row-two lower |
| bypass_row1 | output | 1 | First butterfly row passes data through |
| wr_en | output | 4 | Per-lane write enables |
| wr_addr | output | 4*AW | Per-lane write addresses, lane 0 lowest |
| busy | output | 1 | A transform is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker takes for granted that `log_n` and `inverse` matter only in the cycle a start is accepted. It also takes for granted that the delay it models from a read to each lane's write is the only path from `rd_en` to `wr_en`. Its idle-hold property recomputes the acceptance condition from `start` and `log_n`, so it holds for any stimulus. The bench raises `start` only while idle, except for one deliberate pulse in the middle of a run. It uses two deliberately illegal lengths, and it changes `log_n` only around a start pulse.

// File: rtl/ntt_sched_pkg.sv
package ntt_sched_pkg;
  localparam int LANES        = 4;
  localparam int TW_PER_GROUP = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_GAP
  } seq_state_e;
endpackage

// File: rtl/ntt_round_agu.sv
// Combinational address and twiddle-index generator for one read cycle.
module ntt_round_agu
  import ntt_sched_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic [LW-1:0]              log_n,
  input  logic [LW-1:0]              span_lt,
  input  logic [AW-1:0]              k,
  input  logic                       single,
  input  logic                       inverse,
  output logic [LANES*AW-1:0]        rd_addr,
  output logic [TW_PER_GROUP*AW-1:0] tw_idx
);
  logic [AW-1:0] t_step, grp, j_base, m_base, n_mask, tw_base;
  logic [AW-1:0] lane_a [LANES];
  logic [AW-1:0] tw_v   [TW_PER_GROUP];

  always_comb begin
    t_step  = AW'(1) << span_lt;
    grp     = k >> span_lt;
    j_base  = (grp << (span_lt + LW'(2))) | (k & (t_step - AW'(1)));
    m_base  = AW'(1) << (log_n - LW'(2) - span_lt);
    n_mask  = (AW'(1) << log_n) - AW'(1);
    tw_base = m_base + grp;
    tw_v[0] = tw_base;
    tw_v[1] = tw_base << 1;
    tw_v[2] = (tw_base << 1) | AW'(1);
    if (single) begin
      // one layer: second row must pair neighbours, so swap the middle lanes
      lane_a[0] = j_base;
      lane_a[1] = j_base + AW'(2);
      lane_a[2] = j_base + AW'(1);
      lane_a[3] = j_base + AW'(3);
    end else begin
      for (int g = 0; g < LANES; g++) lane_a[g] = j_base + AW'(g) * t_step;
    end
    for (int g = 0; g < LANES; g++) rd_addr[g*AW +: AW] = lane_a[g];
    for (int h = 0; h < TW_PER_GROUP; h++)
      tw_idx[h*AW +: AW] = inverse ? (tw_v[h] ^ n_mask) : tw_v[h];
  end
endmodule

// File: rtl/ntt_wb_lanes.sv
// Per-lane write-back delay; lane g is one cycle deeper than lane g-1.
module ntt_wb_lanes
  import ntt_sched_pkg::*;
#(
  parameter int AW       = 8,
  parameter int BASE_LAT = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*AW-1:0] in_addr,
  output logic [LANES-1:0]    out_valid,
  output logic [LANES*AW-1:0] out_addr
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int DEPTH = BASE_LAT + g;
    logic [DEPTH-1:0] vld_sr;
    logic [AW-1:0]    adr_sr [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_sr <= '0;
        for (int d = 0; d < DEPTH; d++) adr_sr[d] <= '0;
      end else begin
        vld_sr    <= {vld_sr[DEPTH-2:0], in_valid};
        adr_sr[0] <= in_addr[g*AW +: AW];
        for (int d = 1; d < DEPTH; d++) adr_sr[d] <= adr_sr[d-1];
      end
    end

    assign out_valid[g]          = vld_sr[DEPTH-1];
    assign out_addr[g*AW +: AW]  = adr_sr[DEPTH-1];
  end
endmodule

// File: rtl/ntt_merge_sched.sv
module ntt_merge_sched
  import ntt_sched_pkg::*;
#(
  parameter int LOG_N_MAX = 8,
  parameter int RD_LAT    = 2,
  parameter int BF_LAT    = 8,
  parameter int BUF_LAT   = 4,
  parameter int IDLE_GAP  = 6,
  localparam int AW = LOG_N_MAX,
  localparam int LW = $clog2(LOG_N_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       inverse,
  input  logic [LW-1:0]              log_n,
  output logic                       rd_en,
  output logic [LANES*AW-1:0]        rd_addr,
  output logic [TW_PER_GROUP*AW-1:0] tw_idx,
  output logic                       bypass_row1,
  output logic [LANES-1:0]           wr_en,
  output logic [LANES*AW-1:0]        wr_addr,
  output logic                       busy,
  output logic                       done
);
  localparam int WB_LAT   = RD_LAT + BF_LAT + BUF_LAT;
  localparam int LAST_LAT = WB_LAT + LANES - 1;
  localparam int GAP_LEN  = LAST_LAT + IDLE_GAP;
  localparam int GW       = $clog2(GAP_LEN + 1);

  seq_state_e    state;
  logic          inv_q, done_q;
  logic [LW-1:0] logn_q, rnd;
  logic [AW-1:0] k_cnt;
  logic [GW-1:0] gap_cnt;

  logic [LW-1:0] rnd_last_fwd, two_r, lt_room, span_lt;
  logic [AW-1:0] k_end;
  logic          last_fwd, last_round, single_rd, start_ok;

  always_comb begin
    rnd_last_fwd = (logn_q - LW'(1)) >> 1;
    last_fwd     = (rnd == rnd_last_fwd);
    last_round   = inv_q ? (rnd == '0) : last_fwd;
    two_r        = rnd << 1;
    lt_room      = logn_q - LW'(2);
    span_lt      = (lt_room >= two_r) ? (lt_room - two_r) : '0;
    single_rd    = logn_q[0] && last_fwd;
    k_end        = (AW'(1) << lt_room) - AW'(1);
    start_ok     = start && (log_n >= LW'(2)) && (log_n <= LW'(LOG_N_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      inv_q   <= 1'b0;
      logn_q  <= LW'(2);
      rnd     <= '0;
      k_cnt   <= '0;
      gap_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (start_ok) begin
          inv_q  <= inverse;
          logn_q <= log_n;
          k_cnt  <= '0;
          rnd    <= inverse ? ((log_n - LW'(1)) >> 1) : '0;
          state  <= SEQ_READ;
        end
        SEQ_READ: if (k_cnt == k_end) begin
          k_cnt   <= '0;
          gap_cnt <= '0;
          state   <= SEQ_GAP;
        end else begin
          k_cnt <= k_cnt + AW'(1);
        end
        SEQ_GAP: begin
          if (last_round && gap_cnt == GW'(LAST_LAT - 1)) begin
            state  <= SEQ_IDLE;
            done_q <= 1'b1;
          end else if (!last_round && gap_cnt == GW'(GAP_LEN - 1)) begin
            state <= SEQ_READ;
            rnd   <= inv_q ? (rnd - LW'(1)) : (rnd + LW'(1));
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_en       = (state == SEQ_READ);
  assign bypass_row1 = rd_en && single_rd;
  assign busy        = (state != SEQ_IDLE);
  assign done        = done_q;

  ntt_round_agu #(.AW(AW), .LW(LW)) u_agu (
    .log_n   (logn_q),
    .span_lt (span_lt),
    .k       (k_cnt),
    .single  (single_rd),
    .inverse (inv_q),
    .rd_addr (rd_addr),
    .tw_idx  (tw_idx)
  );

  ntt_wb_lanes #(.AW(AW), .BASE_LAT(WB_LAT)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_en),
    .in_addr   (rd_addr),
    .out_valid (wr_en),
    .out_addr  (wr_addr)
  );
endmodule

// File: rtl/ntt_merge_sched_chk.sv
module ntt_merge_sched_chk
  import ntt_sched_pkg::*;
#(
  parameter int LOG_N_MAX = 8,
  parameter int RD_LAT    = 2,
  parameter int BF_LAT    = 8,
  parameter int BUF_LAT   = 4,
  localparam int LW = $clog2(LOG_N_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LW-1:0]    log_n,
  input logic             rd_en,
  input logic             bypass_row1,
  input logic [LANES-1:0] wr_en,
  input logic             busy,
  input logic             done
);
  localparam int WB_LAT   = RD_LAT + BF_LAT + BUF_LAT;
  localparam int LAST_LAT = WB_LAT + LANES - 1;

  logic [LAST_LAT-1:0] rd_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_hist <= '0;
    else        rd_hist <= {rd_hist[LAST_LAT-2:0], rd_en};
  end

  // R3
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && log_n >= LW'(2) && log_n <= LW'(LOG_N_MAX))) |=> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_en && wr_en == '0));

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  bypass_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_row1 |-> rd_en);

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    // R7
    wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] == rd_hist[WB_LAT+g-1]);
  end
endmodule

bind ntt_merge_sched ntt_merge_sched_chk #(
  .LOG_N_MAX(LOG_N_MAX), .RD_LAT(RD_LAT), .BF_LAT(BF_LAT), .BUF_LAT(BUF_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .log_n(log_n), .rd_en(rd_en),
  .bypass_row1(bypass_row1), .wr_en(wr_en), .busy(busy), .done(done)
);

// File: tb/ntt_merge_sched_test.sv
module ntt_merge_sched_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8;
  localparam int LW = 4;
  localparam int WB_LAT = 14;
  // log_n, inverse, cycles first-read..done, total reads
  localparam int VEC [7][4] = '{
    '{4, 0, 48, 8},  '{4, 1, 48, 8},  '{5, 0, 87, 24}, '{5, 1, 87, 24},
    '{2, 0, 18, 1},  '{3, 1, 44, 4},  '{8, 0, 342, 256}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, inverse = 1'b0;
  logic [LW-1:0] log_n = '0;
  logic rd_en, bypass_row1, busy, done;
  logic [4*AW-1:0] rd_addr, wr_addr;
  logic [3*AW-1:0] tw_idx;
  logic [3:0] wr_en;

  always #2.5 clk = ~clk;

  ntt_merge_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse), .log_n(log_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .tw_idx(tw_idx), .bypass_row1(bypass_row1),
    .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0;
  int f_a [512][4]; int f_t [512][3]; bit f_s [512];
  int e_a [512][4]; int e_t [512][3]; bit e_s [512];
  int e_n, nr;
  bit hv [2048]; int ha [2048][4];

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic build_ref(input int L, input bit inv);
    int n, q, fc, src;
    n = 1 << L; q = n / 4; fc = 0; nr = 0;
    for (int s = 0; s + 1 < L; s += 2) begin
      int m, t;
      m = 1 << s; t = n / (4 * m);
      for (int i = 0; i < m; i++)
        for (int j = 4 * i * t; j < 4 * i * t + t; j++) begin
          f_a[fc][0] = j; f_a[fc][1] = j + t; f_a[fc][2] = j + 2 * t; f_a[fc][3] = j + 3 * t;
          f_t[fc][0] = m + i; f_t[fc][1] = 2 * (m + i); f_t[fc][2] = 2 * (m + i) + 1;
          f_s[fc] = 1'b0; fc++;
        end
      nr++;
    end
    if (L % 2 == 1) begin
      for (int p = 0; p < q; p++) begin
        f_a[fc][0] = 4 * p; f_a[fc][1] = 4 * p + 2; f_a[fc][2] = 4 * p + 1; f_a[fc][3] = 4 * p + 3;
        f_t[fc][0] = q + p; f_t[fc][1] = 2 * q + 2 * p; f_t[fc][2] = 2 * q + 2 * p + 1;
        f_s[fc] = 1'b1; fc++;
      end
      nr++;
    end
    e_n = 0;
    for (int r = 0; r < nr; r++) begin
      src = inv ? nr - 1 - r : r;
      for (int p = 0; p < q; p++) begin
        for (int x = 0; x < 4; x++) e_a[e_n][x] = f_a[src * q + p][x];
        for (int h = 0; h < 3; h++)
          e_t[e_n][h] = inv ? (n - 1 - f_t[src * q + p][h]) : f_t[src * q + p][h];
        e_s[e_n] = f_s[src * q + p];
        e_n++;
      end
    end
  endtask

  task automatic run(input int L, input bit inv, input int exp_d, input int exp_reads, input bit poke);
    int cyc, rd_idx, first_rd, done_cyc, last_wr, runs, prev_rd;
    int bad_a, bad_t, bad_s, bad_w, bad_gap, bad_busy, act_v, exp_v;
    build_ref(L, inv);
    @(negedge clk); log_n = LW'(L); inverse = inv; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0; rd_idx = 0; first_rd = -1; done_cyc = -1; last_wr = -100; runs = 0; prev_rd = 0;
    bad_a = 0; bad_t = 0; bad_s = 0; bad_w = 0; bad_gap = 0; bad_busy = 0; act_v = 0; exp_v = 0;
    while (cyc < 1500 && done_cyc < 0) begin
      hv[cyc] = rd_en;
      for (int x = 0; x < 4; x++) ha[cyc][x] = int'(rd_addr[x*AW +: AW]);
      if (rd_en) begin
        if (first_rd < 0) first_rd = cyc;
        if (!prev_rd) begin
          runs++;
          if (runs > 1 && cyc - last_wr != 7) begin bad_gap++; act_v = cyc - last_wr; end
        end
        if (rd_idx < e_n) begin
          for (int x = 0; x < 4; x++) if (ha[cyc][x] != e_a[rd_idx][x]) bad_a++;
          for (int h = 0; h < 3; h++) if (int'(tw_idx[h*AW +: AW]) != e_t[rd_idx][h]) bad_t++;
          if (bypass_row1 != e_s[rd_idx]) bad_s++;
        end
        rd_idx++;
      end else if (bypass_row1) bad_s++;
      prev_rd = rd_en;
      for (int x = 0; x < 4; x++) begin
        bit ev;
        ev = (cyc >= WB_LAT + x) ? hv[cyc - WB_LAT - x] : 1'b0;
        if (wr_en[x] != ev) bad_w++;
        else if (ev && int'(wr_addr[x*AW +: AW]) != ha[cyc - WB_LAT - x][x]) bad_w++;
        if (wr_en[x]) last_wr = cyc;
      end
      if (done) done_cyc = cyc;
      else if (!busy) bad_busy++;
      if (done && busy) bad_busy++;
      start = poke && cyc == 5;
      inverse = (poke && cyc == 5) ? !inv : inv;
      @(negedge clk);
      cyc++;
    end
    check(first_rd == 0, "R2 first read right after start", first_rd, 0);
    check(rd_idx == exp_reads, "R3 total read cycles", rd_idx, exp_reads);
    check(runs == nr, "R3 round count", runs, nr);
    check(bad_a == 0, "R3 read address sequence mismatches", bad_a, 0);
    check(bad_t == 0, inv ? "R6 mirrored twiddle mismatches" : "R4 twiddle mismatches", bad_t, 0);
    check(bad_s == 0, "R5 bypass flag mismatches", bad_s, 0);
    check(bad_w == 0, "R7 write lane enable/address mismatches", bad_w, 0);
    check(bad_gap == 0, "R8 last-write to next-read distance", act_v, 7);
    check(done_cyc - first_rd == exp_d, "R9 first read to done", done_cyc - first_rd, exp_d);
    check(bad_busy == 0, "R9 busy high until done", bad_busy, 0);
    check(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_en == 1'b0 && wr_en == 4'b0 && busy == 1'b0 && done == 1'b0,
          "R1 outputs low in reset", int'({rd_en, wr_en, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_en == 1'b0 && wr_en == 4'b0 && busy == 1'b0 && done == 1'b0,
          "R1 outputs low after release", int'({rd_en, wr_en, busy, done}), 0);

    for (int v = 0; v < 7; v++)
      run(VEC[v][0], VEC[v][1] != 0, VEC[v][2], VEC[v][3], 1'b0);

    // R2: start while busy (different mode) is ignored
    run(5, 1'b0, 87, 24, 1'b1);

    // R2: out-of-range lengths are refused
    for (int bad = 0; bad < 2; bad++) begin
      int seen;
      seen = 0;
      @(negedge clk); log_n = (bad == 0) ? LW'(1) : LW'(9); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < 8; c++) begin
        if (busy || rd_en) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R2 illegal length ignored", seen, 0);
    end

    // R10: reset during a run
    @(negedge clk); log_n = LW'(6); inverse = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0 && rd_en == 1'b0 && wr_en == 4'b0,
          "R10 reset mid-run clears outputs", int'({busy, rd_en, wr_en}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && wr_en == 4'b0, "R10 idle after release", int'({busy, wr_en}), 0);
    run(4, 1'b1, 48, 8, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule